// File: doc/BRIEF.md
# Bus Master Security Gate

This block sits on the path between one bus master and the memory bus behind it. For every request it works out whether the master may reach the target address. Requests that are allowed go downstream unchanged. Requests that are refused never leave the block and are answered locally. The block has no register interface. Two hardwired inputs set it up: one says whether the master counts as non-secure, and the other picks how a refused request is answered. The answer is either an error response, or a normal completion that returns zero on reads and drops writes.

The security of each address comes from a small built-in attribution unit. It holds a set of secure windows, and each window has an inclusive base and an inclusive limit, both set by parameters. A refusal happens only when a non-secure master targets a secure address. Every refusal sets a sticky interrupt, and a clear input removes it. Both ports use a valid/ready request channel and a single-beat response. The gate allows one transaction in flight at a time.

Top module: `bus_sec_gate`

## Requirements
- R1: After reset, `irq_out` is 0, `up_rsp_valid` is 0 and `dn_req_valid` is 0. With no request pending and `dn_req_ready` high, `up_req_ready` is 1.
- R2: When `cfg_master_ns` is 0, every request is forwarded, including requests to secure addresses. `dn_nonsec` is 0 for a secure address and 1 for a non-secure address.
- R3: When `cfg_master_ns` is 1 and the address is non-secure, the request is forwarded with `dn_nonsec` = 1.
- R4: When `cfg_master_ns` is 1 and the address is secure, the request is refused. `dn_req_valid` stays 0 for that request.
- R5: When `cfg_err_resp` is 1, a refused request gets `up_rsp_valid` = 1 with `up_rsp_err` = 1 and `up_rdata` = 0, in the cycle after it is accepted.
- R6: When `cfg_err_resp` is 0, a refused request gets `up_rsp_valid` = 1 with `up_rsp_err` = 0 and `up_rdata` = 0, in the cycle after it is accepted. A refused write never appears downstream.
- R7: `irq_out` goes to 1 in the cycle after a refused request is accepted. It then stays at 1 until it is cleared.
- R8: `irq_out` falls in the cycle after `irq_clr` is sampled high. If `irq_clr` is high in the same cycle that a refusal is accepted, `irq_out` stays at 1.
- R9: An address is secure when `SEC0_BASE <= addr <= SEC0_LIMIT` or `SEC1_BASE <= addr <= SEC1_LIMIT`. Both bounds are inclusive. Every other address is non-secure. The defaults are 0x1000–0x1FFF and 0x8000–0x80FF.
- R10: `cfg_err_resp` is captured when the request is accepted. Changing it afterwards does not alter the response already in flight.
- R11: For a forwarded request, `up_req_ready` follows `dn_req_ready` in the same cycle. The downstream response (`dn_rsp_valid`, `dn_rsp_err`, `dn_rdata`) appears on the upstream response in the same cycle.
- R12: While a forwarded request waits for its response, `up_req_ready` and `dn_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master_ns | input | 1 | 1: the master is non-secure; 0: the master is secure |
| cfg_err_resp | input | 1 | 1: refused requests get an error; 0: refused requests read as zero and drop writes |
| irq_clr | input | 1 | Clears the refusal interrupt |
| irq_out | output | 1 | Sticky refusal interrupt |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_addr | input | AW | Request address |
| up_write | input | 1 | 1 for a write |
| up_wdata | input | DW | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_err | output | 1 | Upstream response error |
| up_rdata | output | DW | Upstream read data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_addr | output | AW | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | DW | Downstream write data |
| dn_nonsec | output | 1 | Non-secure attribute of the forwarded request |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_err | input | 1 | Downstream response error |
| dn_rdata | input | DW | Downstream read data |

## Verification
If the local-response flag is stuck or wrong, it shows at the upstream response one cycle after a refusal is accepted. The response is then missing, carries the wrong error bit, or returns non-zero data. If the outstanding flag is wrong, `up_req_ready` is raised while a forwarded response is still due, or is held low after that response. This shows on the very next request. A wrong interrupt register shows on `irq_out` one cycle after a refusal or a clear. The bench checks each of these at the first cycle where the fault could appear, and covers the window bounds on both sides.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    // Registered state of the transaction controller
    typedef struct packed {
        logic fwd_busy;   // forwarded request waiting for its downstream response
        logic loc_busy;   // local answer to a refused request is being driven
        logic loc_err;    // error bit captured when the refusal was accepted
    } gate_state_t;

endpackage

// File: rtl/sec_attrib.sv
module sec_attrib #(
    parameter int AW     = 16,
    parameter int NRANGE = 2,
    parameter logic [NRANGE-1:0][AW-1:0] BASES  = '0,
    parameter logic [NRANGE-1:0][AW-1:0] LIMITS = '0
) (
    input  logic [AW-1:0] addr,
    output logic          is_secure
);

    logic [NRANGE-1:0] hit;

    // One inclusive window comparator per secure range
    for (genvar i = 0; i < NRANGE; i++) begin : g_win
        assign hit[i] = (addr >= BASES[i]) && (addr <= LIMITS[i]);
    end

    assign is_secure = |hit;

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
    import sec_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic reject,
    input  logic cfg_err_resp,
    input  logic dn_ready,
    input  logic dn_rsp_valid,
    output logic up_ready,
    output logic dn_valid,
    output logic rej_accept,
    output logic loc_rsp_valid,
    output logic loc_rsp_err
);

    gate_state_t st_d, st_q;
    logic        idle;

    assign idle          = !st_q.fwd_busy && !st_q.loc_busy;
    assign up_ready      = idle && (reject || dn_ready);
    assign dn_valid      = req_valid && !reject && idle;
    assign rej_accept    = req_valid && up_ready && reject;
    assign loc_rsp_valid = st_q.loc_busy;
    assign loc_rsp_err   = st_q.loc_err;

    always_comb begin
        st_d = st_q;
        if (dn_valid && dn_ready) begin
            st_d.fwd_busy = 1'b1;
        end else if (dn_rsp_valid) begin
            st_d.fwd_busy = 1'b0;
        end
        st_d.loc_busy = rej_accept;
        if (rej_accept) begin
            st_d.loc_err = cfg_err_resp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    loc_rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_accept |=> loc_rsp_valid);

    // R12
    no_second_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) |=> (!up_ready && !dn_valid));

endmodule

// File: rtl/irq_latch.sv
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set) begin
            irq_d = 1'b1;
        end else if (clr) begin
            irq_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    // R7
    irq_on_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);

    // R8
    irq_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !irq);

endmodule

// File: rtl/bus_sec_gate.sv
module bus_sec_gate #(
    parameter int            AW         = 16,
    parameter int            DW         = 32,
    parameter logic [AW-1:0] SEC0_BASE  = 16'h1000,
    parameter logic [AW-1:0] SEC0_LIMIT = 16'h1FFF,
    parameter logic [AW-1:0] SEC1_BASE  = 16'h8000,
    parameter logic [AW-1:0] SEC1_LIMIT = 16'h80FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master_ns,
    input  logic          cfg_err_resp,
    input  logic          irq_clr,
    output logic          irq_out,
    input  logic          up_req_valid,
    output logic          up_req_ready,
    input  logic [AW-1:0] up_addr,
    input  logic          up_write,
    input  logic [DW-1:0] up_wdata,
    output logic          up_rsp_valid,
    output logic          up_rsp_err,
    output logic [DW-1:0] up_rdata,
    output logic          dn_req_valid,
    input  logic          dn_req_ready,
    output logic [AW-1:0] dn_addr,
    output logic          dn_write,
    output logic [DW-1:0] dn_wdata,
    output logic          dn_nonsec,
    input  logic          dn_rsp_valid,
    input  logic          dn_rsp_err,
    input  logic [DW-1:0] dn_rdata
);

    localparam int NRANGE = 2;
    localparam logic [NRANGE-1:0][AW-1:0] BASES  = {SEC1_BASE, SEC0_BASE};
    localparam logic [NRANGE-1:0][AW-1:0] LIMITS = {SEC1_LIMIT, SEC0_LIMIT};

    logic addr_secure;
    logic reject;
    logic rej_accept;
    logic loc_rsp_valid;
    logic loc_rsp_err;

    sec_attrib #(
        .AW     (AW),
        .NRANGE (NRANGE),
        .BASES  (BASES),
        .LIMITS (LIMITS)
    ) u_attrib (
        .addr      (up_addr),
        .is_secure (addr_secure)
    );

    assign reject = cfg_master_ns && addr_secure;

    gate_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (up_req_valid),
        .reject        (reject),
        .cfg_err_resp  (cfg_err_resp),
        .dn_ready      (dn_req_ready),
        .dn_rsp_valid  (dn_rsp_valid),
        .up_ready      (up_req_ready),
        .dn_valid      (dn_req_valid),
        .rej_accept    (rej_accept),
        .loc_rsp_valid (loc_rsp_valid),
        .loc_rsp_err   (loc_rsp_err)
    );

    irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rej_accept),
        .clr   (irq_clr),
        .irq   (irq_out)
    );

    // Request fields pass through; only valid is gated
    assign dn_addr   = up_addr;
    assign dn_write  = up_write;
    assign dn_wdata  = up_wdata;
    assign dn_nonsec = !addr_secure;

    // Local answer takes the response channel while it is active
    assign up_rsp_valid = loc_rsp_valid || dn_rsp_valid;
    assign up_rsp_err   = loc_rsp_valid ? loc_rsp_err : dn_rsp_err;
    assign up_rdata     = loc_rsp_valid ? '0 : dn_rdata;

    // R4
    refused_stays_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !(cfg_master_ns && addr_secure));

    // R6
    refused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_ready && reject) |=> (up_rsp_valid && up_rdata == '0));

    // R10
    err_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_ready && reject) |=> (up_rsp_err == $past(cfg_err_resp)));

endmodule

// File: tb/tb_bus_sec_gate.sv
module tb_bus_sec_gate;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_master_ns = 1'b0;
    logic          cfg_err_resp = 1'b0;
    logic          irq_clr = 1'b0;
    logic          irq_out;
    logic          up_req_valid = 1'b0;
    logic          up_req_ready;
    logic [AW-1:0] up_addr = '0;
    logic          up_write = 1'b0;
    logic [DW-1:0] up_wdata = '0;
    logic          up_rsp_valid;
    logic          up_rsp_err;
    logic [DW-1:0] up_rdata;
    logic          dn_req_valid;
    logic          dn_req_ready = 1'b1;
    logic [AW-1:0] dn_addr;
    logic          dn_write;
    logic [DW-1:0] dn_wdata;
    logic          dn_nonsec;
    logic          dn_rsp_valid = 1'b0;
    logic          dn_rsp_err = 1'b0;
    logic [DW-1:0] dn_rdata = '0;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    bus_sec_gate dut (
        .clk(clk), .rst_n(rst_n), .cfg_master_ns(cfg_master_ns),
        .cfg_err_resp(cfg_err_resp), .irq_clr(irq_clr), .irq_out(irq_out),
        .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
        .up_addr(up_addr), .up_write(up_write), .up_wdata(up_wdata),
        .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rdata(up_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
        .dn_addr(dn_addr), .dn_write(dn_write), .dn_wdata(dn_wdata),
        .dn_nonsec(dn_nonsec), .dn_rsp_valid(dn_rsp_valid),
        .dn_rsp_err(dn_rsp_err), .dn_rdata(dn_rdata)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit is_sec(logic [AW-1:0] a);
        return (a >= 16'h1000 && a <= 16'h1FFF) || (a >= 16'h8000 && a <= 16'h80FF);
    endfunction

    // Forwarded transaction; called and returns at a negedge
    task automatic do_fwd(string tag, logic ns, logic [AW-1:0] a, logic wr);
        logic [DW-1:0] rd;
        rd = {a, 16'hA5C3};
        cfg_master_ns = ns;
        up_req_valid = 1'b1; up_addr = a; up_write = wr; up_wdata = ~rd;
        #1;
        chk({tag, " fwd valid"}, dn_req_valid, 1);
        chk({tag, " fwd nonsec"}, dn_nonsec, !is_sec(a));
        chk({tag, " fwd addr"}, dn_addr, a);
        @(posedge clk);
        @(negedge clk);
        up_req_valid = 1'b0;
        dn_rsp_valid = 1'b1; dn_rdata = rd; dn_rsp_err = 1'b0;
        #1;
        chk({tag, " R11 rsp pass valid"}, up_rsp_valid, 1);
        chk({tag, " R11 rsp pass data"}, up_rdata, rd);
        @(negedge clk);
        dn_rsp_valid = 1'b0;
    endtask

    // Refused transaction; flip changes cfg_err_resp after acceptance
    task automatic do_rej(string tag, logic [AW-1:0] a, logic err, logic wr,
                          logic clr, logic flip);
        cfg_master_ns = 1'b1; cfg_err_resp = err; irq_clr = clr;
        up_req_valid = 1'b1; up_addr = a; up_write = wr; up_wdata = 32'hDEAD_BEEF;
        #1;
        chk({tag, " R4 not forwarded"}, dn_req_valid, 0);
        chk({tag, " R4 accepted"}, up_req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        up_req_valid = 1'b0; irq_clr = 1'b0;
        if (flip) cfg_err_resp = !err;
        #1;
        chk({tag, " rsp valid"}, up_rsp_valid, 1);
        chk({tag, " rsp err"}, up_rsp_err, err);
        chk({tag, " rsp data zero"}, up_rdata, 0);
        chk({tag, " R7 irq set"}, irq_out, 1);
        chk({tag, " R6 never downstream"}, dn_req_valid, 0);
        @(negedge clk);
        chk({tag, " rsp one beat"}, up_rsp_valid, 0);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", irq_out, 0);
        chk("R1 rsp valid", up_rsp_valid, 0);
        chk("R1 dn valid", dn_req_valid, 0);
        chk("R1 ready", up_req_ready, 1);
    endtask

    task automatic t_secure_master();
        do_fwd("R2 sec->sec", 1'b0, 16'h1234, 1'b0);
        do_fwd("R2 sec->ns", 1'b0, 16'h4000, 1'b1);
        chk("R2 no irq", irq_out, 0);
    endtask

    task automatic t_ns_master();
        do_fwd("R3 ns->ns", 1'b1, 16'h4000, 1'b0);
        do_rej("R5 err resp", 16'h1800, 1'b1, 1'b0, 1'b0, 1'b0);
        do_rej("R6 raz write", 16'h8010, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_irq();
        repeat (3) @(negedge clk);
        chk("R7 sticky", irq_out, 1);
        clear_irq();
        chk("R8 cleared", irq_out, 0);
        do_rej("R8 clr vs set", 16'h1000, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R8 set wins", irq_out, 1);
        clear_irq();
    endtask

    task automatic t_bounds();
        do_fwd("R9 below0", 1'b1, 16'h0FFF, 1'b0);
        do_rej("R9 base0", 16'h1000, 1'b1, 1'b0, 1'b0, 1'b0);
        do_rej("R9 limit0", 16'h1FFF, 1'b1, 1'b0, 1'b0, 1'b0);
        do_fwd("R9 above0", 1'b1, 16'h2000, 1'b0);
        do_fwd("R9 below1", 1'b1, 16'h7FFF, 1'b0);
        do_rej("R9 base1", 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0);
        do_rej("R9 limit1", 16'h80FF, 1'b0, 1'b0, 1'b0, 1'b0);
        do_fwd("R9 above1", 1'b1, 16'h8100, 1'b0);
        clear_irq();
    endtask

    task automatic t_sample();
        do_rej("R10 late flip err", 16'h1100, 1'b1, 1'b0, 1'b0, 1'b1);
        do_rej("R10 late flip raz", 16'h1100, 1'b0, 1'b0, 1'b0, 1'b1);
        clear_irq();
    endtask

    task automatic t_backpressure();
        cfg_master_ns = 1'b1; dn_req_ready = 1'b0;
        up_req_valid = 1'b1; up_addr = 16'h3000; up_write = 1'b0;
        #1;
        chk("R11 ready follows low", up_req_ready, 0);
        chk("R11 valid offered", dn_req_valid, 1);
        @(negedge clk);
        dn_req_ready = 1'b1;
        #1;
        chk("R11 ready follows high", up_req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        up_addr = 16'h3004;
        #1;
        chk("R12 ready held", up_req_ready, 0);
        chk("R12 no issue", dn_req_valid, 0);
        @(negedge clk);
        chk("R12 still waiting", up_req_ready, 0);
        up_req_valid = 1'b0;
        dn_rsp_valid = 1'b1; dn_rsp_err = 1'b1; dn_rdata = 32'h0BAD_0BAD;
        #1;
        chk("R11 err passthrough", up_rsp_err, 1);
        chk("R11 data passthrough", up_rdata, 32'h0BAD_0BAD);
        @(negedge clk);
        dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0;
        #1;
        chk("R12 ready again", up_req_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_secure_master();
        t_ns_master();
        t_irq();
        t_bounds();
        t_sample();
        t_backpressure();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule